// File: doc/BRIEF.md
# Command-List Data Channel

This block is a data channel placed between a device controller and a 36-bit main memory. The CPU loads a list address and a direction, then pulses start. From then on the channel works alone. It reads control words from memory one after another and carries out each one. A control word can stop the list, send the channel to another list, throw away device words, or move words between the device and consecutive memory locations.

Each control word packs a negated word count and a memory address. The count runs upward toward zero, one step per word. After every move or discard command finishes, the channel writes a status word to a fixed location so that software can see the final count and address. If the device ends its record early, the list stops and a short-record flag is set. The CPU can also cancel a running list.

A build parameter selects one of three control-word layouts:
- the base layout: 18-bit count, 18-bit address;
- a wide-address layout: 14-bit count, 22-bit address;
- a split layout: 15-bit count, 21-bit address, with the top three address bits stored inverted.

Top module: `cmdlist_dma`

## Requirements
- R1: While reset is held, and after it is released, busy, done, short-record, irq, mem_req, dev_in_ready and dev_out_valid are all 0.
- R2: Start is accepted only while idle. The first memory access is a read of the list address given with start. Once mem_req rises, it stays high with stable address, write enable and write data until mem_ack.
- R3: An all-zero control word ends the list. Done goes to 1 and busy goes to 0, and no status word is written. Busy and done are never 1 together.
- R4: A control word with a zero count field and a nonzero word is a jump. The next control word is read from its address field, and no status word is written.
- R5: In the base layout, a word's bits [35:18] hold the count and bits [17:0] hold the address. With direction 1 (device to memory), a move command with count field c takes 2^18 - c device words. It writes them to consecutive addresses starting at the address field, and nothing beyond them.
- R6: With direction 0 (memory to device), a move command reads 2^18 - c consecutive memory words from the address field upward. It presents them to the device in that order.
- R7: A word with a nonzero count and a zero address is a discard. With direction 1, it consumes that many device words and writes none to memory. With direction 0, it presents that many zero words to the device.
- R8: When a move or discard command finishes, the channel writes the packed final count and address to location INIT_LOC+1. It then reads the next control word at the list pointer plus one.
- R9: If the device raises end-of-record while the channel waits on it, the list ends. The status word holds the remaining count and the next address, and both short-record and done are set. Start clears short-record.
- R10: An abort pulse finishes the list and sets done. If a memory access is in flight, that access completes first. After an abort the channel makes no further memory or device transfers.
- R11: irq equals done ANDed with the interrupt enable latched at start.
- R12: Wide-address layout: count = word[35:22], address = word[21:0]. Packing the status word uses the same positions.
- R13: Split layout: count = word[32:18], address = {~word[35:33], word[17:0]}. The decode uses this un-inverted address, and packing re-inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | Start pulse from the control register |
| cpu_abort | input | 1 | Abort pulse from the control register |
| cpu_dir | input | 1 | 1 = device to memory, 0 = memory to device |
| cpu_irq_en | input | 1 | Interrupt enable, latched at start |
| cpu_list | input | AW | Address of the first control word |
| stat_busy | output | 1 | List running |
| stat_done | output | 1 | List finished or aborted |
| stat_short | output | 1 | Record ended early |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write cycle |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 36 | Read data, valid with acknowledge |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 36 | Word from the device |
| dev_in_ready | output | 1 | Channel takes a device word |
| dev_out_valid | output | 1 | Channel offers a word to the device |
| dev_out_data | output | 36 | Word to the device |
| dev_out_ready | input | 1 | Device takes the word |
| dev_eor | input | 1 | Device end of record |

## Verification
A CPU abort can arrive in the same cycle as a pending memory access. The channel must let the access finish before it stops. The bench pulses abort while a control-word fetch is held off by a six-cycle memory latency, and device words are ready at that moment. It then judges the outcome from the port-side counts: no device word consumed, no data write, no status write, and done raised. A second abort, given while the channel idles on a silent device, must raise done on the very next cycle.

// File: rtl/chan_pkg.sv
package chan_pkg;

    typedef enum logic [1:0] {
        K_END,
        K_JUMP,
        K_SKIP,
        K_MOVE
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_DIN,
        S_MWR,
        S_MRD,
        S_DOUT,
        S_STEP,
        S_STAT
    } st_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic short_rec;
        logic ien;
    } chan_flags_t;

    // count field width per control-word layout
    function automatic int cnt_width(input int v);
        case (v)
            1:       return 14;
            2:       return 15;
            default: return 18;
        endcase
    endfunction

    // address width per control-word layout
    function automatic int adr_width(input int v);
        case (v)
            1:       return 22;
            2:       return 21;
            default: return 18;
        endcase
    endfunction

    function automatic cmd_e classify(input logic zero_word, input logic cnt_zero,
                                      input logic adr_zero);
        if (zero_word)     return K_END;
        else if (cnt_zero) return K_JUMP;
        else if (adr_zero) return K_SKIP;
        else               return K_MOVE;
    endfunction

endpackage

// File: rtl/ccw_unpack.sv
module ccw_unpack
    import chan_pkg::*;
#(
    parameter int VARIANT = 0,
    localparam int CW = cnt_width(VARIANT),
    localparam int AW = adr_width(VARIANT)
)(
    input  logic [35:0]   word,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] addr,
    output cmd_e          kind
);

    generate
        if (VARIANT == 1) begin : g_wide
            assign cnt  = word[35:22];
            assign addr = word[21:0];
        end else if (VARIANT == 2) begin : g_split
            // top three address bits are kept inverted in the word
            assign cnt  = word[32:18];
            assign addr = {~word[35:33], word[17:0]};
        end else begin : g_base
            assign cnt  = word[35:18];
            assign addr = word[17:0];
        end
    endgenerate

    assign kind = classify(word == 36'd0, cnt == '0, addr == '0);

endmodule

// File: rtl/ccw_pack.sv
module ccw_pack
    import chan_pkg::*;
#(
    parameter int VARIANT = 0,
    localparam int CW = cnt_width(VARIANT),
    localparam int AW = adr_width(VARIANT)
)(
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] addr,
    output logic [35:0]   word
);

    generate
        if (VARIANT == 1) begin : g_wide
            assign word = {cnt, addr};
        end else if (VARIANT == 2) begin : g_split
            assign word = {~addr[20:18], cnt, addr[17:0]};
        end else begin : g_base
            assign word = {cnt, addr};
        end
    endgenerate

endmodule

// File: rtl/cmdlist_dma.sv
module cmdlist_dma
    import chan_pkg::*;
#(
    parameter int VARIANT  = 0,
    parameter int INIT_LOC = 0,
    localparam int CW = cnt_width(VARIANT),
    localparam int AW = adr_width(VARIANT)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_start,
    input  logic          cpu_abort,
    input  logic          cpu_dir,
    input  logic          cpu_irq_en,
    input  logic [AW-1:0] cpu_list,
    output logic          stat_busy,
    output logic          stat_done,
    output logic          stat_short,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [35:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [35:0]   mem_rdata,
    input  logic          dev_in_valid,
    input  logic [35:0]   dev_in_data,
    output logic          dev_in_ready,
    output logic          dev_out_valid,
    output logic [35:0]   dev_out_data,
    input  logic          dev_out_ready,
    input  logic          dev_eor
);

    localparam logic [AW-1:0] STAT_LOC = AW'(INIT_LOC + 1);

    st_e           st;
    st_e           move_st;
    chan_flags_t   fl;
    cmd_e          cur_kind;
    cmd_e          f_kind;
    logic [AW-1:0] lp;
    logic [AW-1:0] cur_adr;
    logic [AW-1:0] f_adr;
    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] f_cnt;
    logic [CW-1:0] cnt_nx;
    logic [35:0]   dbuf;
    logic [35:0]   stat_word;
    logic          dir_in;
    logic          abort_pend;
    logic          take_abort;

    ccw_unpack #(.VARIANT(VARIANT)) u_unpack (
        .word (mem_rdata),
        .cnt  (f_cnt),
        .addr (f_adr),
        .kind (f_kind)
    );

    ccw_pack #(.VARIANT(VARIANT)) u_pack (
        .cnt  (cur_cnt),
        .addr (cur_adr),
        .word (stat_word)
    );

    always_comb begin
        mem_req = (st == S_FETCH) || (st == S_MWR) || (st == S_MRD) || (st == S_STAT);
        mem_we  = (st == S_MWR) || (st == S_STAT);
        case (st)
            S_FETCH:      mem_addr = lp;
            S_MWR, S_MRD: mem_addr = cur_adr;
            S_STAT:       mem_addr = STAT_LOC;
            default:      mem_addr = '0;
        endcase
        if (st == S_STAT)     mem_wdata = stat_word;
        else if (st == S_MWR) mem_wdata = dbuf;
        else                  mem_wdata = '0;
        dev_in_ready  = (st == S_DIN);
        dev_out_valid = (st == S_DOUT);
        dev_out_data  = dbuf;
        cnt_nx        = cur_cnt + CW'(1);
        // an abort waits for any in-flight memory handshake
        take_abort    = fl.busy && (abort_pend || cpu_abort) && !mem_req;
        if (dir_in)                 move_st = S_DIN;
        else if (cur_kind == K_MOVE) move_st = S_MRD;
        else                         move_st = S_DOUT;
    end

    assign stat_busy  = fl.busy;
    assign stat_done  = fl.done;
    assign stat_short = fl.short_rec;
    assign irq        = fl.done & fl.ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            fl         <= '0;
            cur_kind   <= K_END;
            lp         <= '0;
            cur_adr    <= '0;
            cur_cnt    <= '0;
            dbuf       <= '0;
            dir_in     <= 1'b0;
            abort_pend <= 1'b0;
        end else begin
            if (fl.busy && cpu_abort) abort_pend <= 1'b1;
            if (take_abort) begin
                fl.busy    <= 1'b0;
                fl.done    <= 1'b1;
                abort_pend <= 1'b0;
                st         <= S_IDLE;
            end else begin
                case (st)
                    S_IDLE: if (cpu_start) begin
                        lp         <= cpu_list;
                        dir_in     <= cpu_dir;
                        fl         <= '{busy: 1'b1, done: 1'b0, short_rec: 1'b0, ien: cpu_irq_en};
                        abort_pend <= 1'b0;
                        st         <= S_FETCH;
                    end
                    S_FETCH: if (mem_ack) begin
                        cur_cnt  <= f_cnt;
                        cur_adr  <= f_adr;
                        cur_kind <= f_kind;
                        st       <= S_EXEC;
                    end
                    S_EXEC: begin
                        dbuf <= '0;
                        case (cur_kind)
                            K_END: begin
                                fl.busy <= 1'b0;
                                fl.done <= 1'b1;
                                st      <= S_IDLE;
                            end
                            K_JUMP: begin
                                lp <= cur_adr;
                                st <= S_FETCH;
                            end
                            default: st <= move_st;
                        endcase
                    end
                    S_DIN: begin
                        if (dev_in_valid) begin
                            dbuf <= dev_in_data;
                            st   <= (cur_kind == K_MOVE) ? S_MWR : S_STEP;
                        end else if (dev_eor) begin
                            fl.short_rec <= 1'b1;
                            st           <= S_STAT;
                        end
                    end
                    S_MWR: if (mem_ack) st <= S_STEP;
                    S_MRD: if (mem_ack) begin
                        dbuf <= mem_rdata;
                        st   <= S_DOUT;
                    end
                    S_DOUT: begin
                        if (dev_out_ready) begin
                            st <= S_STEP;
                        end else if (dev_eor) begin
                            fl.short_rec <= 1'b1;
                            st           <= S_STAT;
                        end
                    end
                    S_STEP: begin
                        cur_cnt <= cnt_nx;
                        if (cur_kind == K_MOVE) cur_adr <= cur_adr + AW'(1);
                        dbuf <= '0;
                        st   <= (cnt_nx == '0) ? S_STAT : move_st;
                    end
                    S_STAT: if (mem_ack) begin
                        if (fl.short_rec) begin
                            fl.busy <= 1'b0;
                            fl.done <= 1'b1;
                            st      <= S_IDLE;
                        end else begin
                            lp <= lp + AW'(1);
                            st <= S_FETCH;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R2: memory request holds its cycle until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: start from idle makes the channel busy and clears done
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!stat_busy && cpu_start) |=> (stat_busy && !stat_done));

    // R3: busy and done never together
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(stat_busy && stat_done));

    // R10: an idle channel drives no memory or device traffic
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !stat_busy |-> (!mem_req && !dev_in_ready && !dev_out_valid));

    // R7: device input and output handshakes are never offered together
    p_dev_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(dev_in_ready && dev_out_valid));

    // R9: a short record is followed at once by the status write
    p_short_stat_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_short) |-> (mem_req && mem_we && mem_addr == STAT_LOC));

endmodule

// File: tb/cmdlist_dma_tb.sv
`timescale 1ns/1ps
module cmdlist_dma_tb;
    import chan_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        cpu_start, cpu_abort, cpu_dir, cpu_irq_en;
    logic [17:0] cpu_list;
    logic        stat_busy, stat_done, stat_short, irq;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        dev_in_valid, dev_in_ready;
    logic [35:0] dev_in_data;
    logic        dev_out_valid;
    logic [35:0] dev_out_data;
    logic        dev_out_ready;
    logic        dev_eor;

    int vectors = 0;
    int fails   = 0;

    cmdlist_dma #(.VARIANT(0), .INIT_LOC(0)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_start(cpu_start), .cpu_abort(cpu_abort), .cpu_dir(cpu_dir),
        .cpu_irq_en(cpu_irq_en), .cpu_list(cpu_list),
        .stat_busy(stat_busy), .stat_done(stat_done), .stat_short(stat_short), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .dev_eor(dev_eor)
    );

    // layout decoders for the two other variants
    logic [35:0] uw1, uw2, pw1, pw2;
    logic [13:0] c1;
    logic [21:0] a1;
    logic [14:0] c2;
    logic [20:0] a2;
    cmd_e        k1, k2;
    ccw_unpack #(.VARIANT(1)) u_unp1 (.word(uw1), .cnt(c1), .addr(a1), .kind(k1));
    ccw_unpack #(.VARIANT(2)) u_unp2 (.word(uw2), .cnt(c2), .addr(a2), .kind(k2));
    ccw_pack   #(.VARIANT(1)) u_pk1  (.cnt(c1), .addr(a1), .word(pw1));
    ccw_pack   #(.VARIANT(2)) u_pk2  (.cnt(c2), .addr(a2), .word(pw2));

    // memory and device models
    logic [35:0] mem [0:255];
    logic [35:0] din_q [0:63];
    logic [35:0] dout_q [0:63];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [35:0] ld_d = '0;
    logic        clr_log = 1'b0;
    int lat = 0, lat_cnt = 0, stat_writes = 0, data_writes = 0, rd_cnt = 0;
    int din_idx = 0, din_n = 0, eor_at = -1, dout_n = 0;
    logic [17:0] first_rd = '0;

    assign dev_eor       = (eor_at >= 0) && (din_idx >= eor_at);
    assign dev_in_valid  = (din_idx < din_n) && !dev_eor;
    assign dev_in_data   = din_q[din_idx[5:0]];
    assign dev_out_ready = 1'b1;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (ld_en) mem[ld_a] <= ld_d;
        if (clr_log) begin
            stat_writes <= 0; data_writes <= 0; rd_cnt <= 0; lat_cnt <= 0;
            din_idx <= 0; dout_n <= 0;
        end else begin
            if (mem_req && !mem_ack) begin
                if (lat_cnt >= lat) begin
                    mem_ack <= 1'b1;
                    lat_cnt <= 0;
                    if (mem_we) begin
                        mem[mem_addr[7:0]] <= mem_wdata;
                        if (mem_addr == 18'd1) stat_writes <= stat_writes + 1;
                        else                   data_writes <= data_writes + 1;
                    end else begin
                        mem_rdata <= mem[mem_addr[7:0]];
                        if (rd_cnt == 0) first_rd <= mem_addr;
                        rd_cnt <= rd_cnt + 1;
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
            if (dev_in_valid && dev_in_ready) din_idx <= din_idx + 1;
            if (dev_out_valid && dev_out_ready) begin
                dout_q[dout_n[5:0]] <= dev_out_data;
                dout_n <= dout_n + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(input int n, input int a);
        return {18'(-n), 18'(a)};
    endfunction

    task automatic poke(input int a, input logic [35:0] d);
        @(negedge clk);
        ld_a = a[7:0]; ld_d = d; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    task automatic run(input int list, input logic dir, input logic ien);
        @(negedge clk);
        cpu_list = 18'(list); cpu_dir = dir; cpu_irq_en = ien; cpu_start = 1'b1;
        @(negedge clk);
        cpu_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (stat_done) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    logic main_done = 1'b0;

    initial begin
        rst = 1'b1; cpu_start = 0; cpu_abort = 0; cpu_dir = 0; cpu_irq_en = 0; cpu_list = '0;
        fork
            begin : main
                for (int a = 0; a < 128; a++) poke(a, 36'd0);
                clear_log();
                @(negedge clk); rst = 1'b0;
                @(negedge clk);
                // R1 reset state
                chk("R1 busy", stat_busy, 0);
                chk("R1 done", stat_done, 0);
                chk("R1 short", stat_short, 0);
                chk("R1 irq", irq, 0);
                chk("R1 mem_req", mem_req, 0);
                chk("R1 dev handshakes", {dev_in_ready, dev_out_valid}, 0);

                // R5 / R8 / R3 / R11 / R2: sweep of counts and memory latencies
                for (int n = 1; n <= 4; n++) begin
                    for (int l = 0; l < 3; l++) begin
                        lat = l;
                        for (int a = 64; a < 72; a++) poke(a, 36'd0);
                        for (int i = 0; i < n; i++) din_q[i] = 36'(2560 + n*16 + l*4 + i);
                        din_n = n; eor_at = -1;
                        poke(16, mk(n, 64));
                        poke(17, 36'd0);
                        poke(1, 36'd0);
                        clear_log();
                        run(16, 1'b1, l[0]);
                        wait_done();
                        chk("R2 first fetch", first_rd, 18'd16);
                        for (int i = 0; i < n; i++)
                            chk("R5 data word", mem[64+i], 36'(2560 + n*16 + l*4 + i));
                        chk("R5 no overrun", mem[64+n], 36'd0);
                        chk("R8 status word", mem[1], {18'd0, 18'(64+n)});
                        chk("R8 status count", stat_writes, 1);
                        chk("R3 done", {stat_done, stat_busy}, 2'b10);
                        chk("R11 irq", irq, l[0]);
                    end
                end

                // R4 jump
                lat = 1;
                for (int a = 80; a < 84; a++) poke(a, 36'd0);
                din_q[0] = 36'h111; din_q[1] = 36'h222; din_n = 2; eor_at = -1;
                poke(16, {18'd0, 18'd32});
                poke(32, mk(2, 80));
                poke(33, 36'd0);
                clear_log();
                run(16, 1'b1, 1'b0);
                wait_done();
                chk("R4 jump data0", mem[80], 36'h111);
                chk("R4 jump data1", mem[81], 36'h222);
                chk("R4 status", mem[1], {18'd0, 18'd82});
                chk("R4 no status on jump", stat_writes, 1);

                // R7 discard on input
                lat = 0;
                poke(96, 36'd0);
                for (int i = 0; i < 4; i++) din_q[i] = 36'(4000 + i);
                din_n = 4;
                poke(16, mk(3, 0));
                poke(17, mk(1, 96));
                poke(18, 36'd0);
                clear_log();
                run(16, 1'b1, 1'b0);
                wait_done();
                chk("R7 consumed", din_idx, 4);
                chk("R7 one data write", data_writes, 1);
                chk("R7 kept word", mem[96], 36'(4003));
                chk("R8 two status writes", stat_writes, 2);
                chk("R8 final status", mem[1], {18'd0, 18'd97});

                // R6 output and R7 discard on output
                lat = 2;
                poke(112, 36'h5A5A5);
                poke(113, 36'h0F0F0);
                poke(114, 36'h12345);
                poke(16, mk(3, 112));
                poke(17, mk(2, 0));
                poke(18, 36'd0);
                din_n = 0;
                clear_log();
                run(16, 1'b0, 1'b0);
                wait_done();
                chk("R6 out count", dout_n, 5);
                chk("R6 out0", dout_q[0], 36'h5A5A5);
                chk("R6 out1", dout_q[1], 36'h0F0F0);
                chk("R6 out2", dout_q[2], 36'h12345);
                chk("R7 zero out", {dout_q[3], dout_q[4]}, 72'd0);
                chk("R6 no mem writes", data_writes, 0);

                // R9 short record
                lat = 0;
                for (int a = 64; a < 72; a++) poke(a, 36'd0);
                poke(127, 36'd0);
                for (int i = 0; i < 5; i++) din_q[i] = 36'(7000 + i);
                din_n = 5; eor_at = 2;
                poke(16, mk(5, 64));
                poke(17, mk(1, 127));
                clear_log();
                run(16, 1'b1, 1'b1);
                wait_done();
                chk("R9 words written", data_writes, 2);
                chk("R9 word1", mem[65], 36'(7001));
                chk("R9 status", mem[1], {18'(-3), 18'd66});
                chk("R9 short flag", {stat_short, stat_done}, 2'b11);
                chk("R9 list stopped", mem[127], 36'd0);

                // R10 abort during a slow fetch, with device words waiting
                lat = 6; eor_at = -1;
                for (int i = 0; i < 3; i++) din_q[i] = 36'(9000 + i);
                din_n = 3;
                poke(16, mk(3, 64));
                clear_log();
                run(16, 1'b1, 1'b1);
                chk("R9 start clears short", stat_short, 0);
                cpu_abort = 1'b1;
                @(negedge clk); cpu_abort = 1'b0;
                wait_done();
                chk("R10 fetch finished", rd_cnt, 1);
                chk("R10 no device words", din_idx, 0);
                chk("R10 no writes", data_writes + stat_writes, 0);
                chk("R10 done", {stat_done, stat_busy}, 2'b10);

                // R10 abort while waiting on a silent device
                lat = 0; din_n = 0;
                poke(16, mk(50, 64));
                clear_log();
                run(16, 1'b1, 1'b1);
                repeat (20) @(negedge clk);
                chk("R10 still busy", {stat_busy, stat_done}, 2'b10);
                cpu_abort = 1'b1;
                @(negedge clk); cpu_abort = 1'b0;
                chk("R10 done next cycle", stat_done, 1);
                chk("R11 irq on abort", irq, 1);
                repeat (10) @(negedge clk);
                chk("R10 quiet after abort", {mem_req, dev_in_ready, 30'(stat_writes)}, 32'd0);

                // R3 immediate end, R11 disabled
                poke(48, 36'd0);
                clear_log();
                run(48, 1'b1, 1'b0);
                wait_done();
                chk("R3 end no status", stat_writes, 0);
                chk("R11 irq disabled", {irq, stat_done}, 2'b01);

                // R12 / R13 layout sweeps
                for (int hb = 0; hb < 8; hb++) begin
                    for (int r = 0; r < 4; r++) begin
                        for (int c = 0; c < 3; c++) begin
                            logic [17:0] rh;
                            logic [14:0] cn;
                            logic [20:0] ea;
                            logic [1:0]  ek;
                            rh = (r == 0) ? 18'd0 : (r == 1) ? 18'd1 : (r == 2) ? 18'h2AAAA : 18'h3FFFF;
                            cn = (c == 0) ? 15'd0 : (c == 1) ? 15'd1 : 15'h7FFF;
                            uw2 = {hb[2:0], cn, rh};
                            uw1 = {cn[13:0], hb[3:0], rh};
                            #1;
                            ea = {~hb[2:0], rh};
                            if (uw2 == 36'd0)   ek = K_END;
                            else if (cn == 0)   ek = K_JUMP;
                            else if (ea == 0)   ek = K_SKIP;
                            else                ek = K_MOVE;
                            chk("R13 addr", a2, ea);
                            chk("R13 count", c2, cn);
                            chk("R13 kind", k2, ek);
                            chk("R13 repack", pw2, uw2);
                            chk("R12 addr", a1, {hb[3:0], rh});
                            chk("R12 count", c1, cn[13:0]);
                            chk("R12 repack", pw1, uw1);
                        end
                    end
                end
                main_done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
            end
        join_any
        disable fork;
        if (!main_done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule